// File: doc/BRIEF.md
# Boundary-Scan Data Register for a Dual-Side Bus Transceiver

This block is the serial test-data register that wraps the pins of a two-sided bus transceiver. Every pin the transceiver reads from a pad gets an observe-only cell. Every pin it drives gets an observe-and-control cell. Two more observe-and-control cells sit on the internal active-high enables of the A side and the B side. Through these two cells the test logic can switch on or float a whole side with one bit.

A test access port controller outside this block decodes the instruction and the controller state. It hands in four strobes:

- `capture_dr` loads every cell from its parallel input.
- `shift_dr` moves the chain one place toward `tdo` on each rising `tck`.
- `update_dr` copies the chain into the hold latches on the falling `tck`.
- `mode` chooses whether the pads are driven by the system logic or by the hold latches.

A separate one-bit bypass stage shortens the path from `tdi` to `tdo` when `sel_bypass` is high.

Top module: `bsr_chain`

## Requirements
- R1: A synchronous active-low reset (`rst_n` sampled on the test clock) clears every capture/shift flop, every hold latch and the bypass stage to 0. With `mode` high after reset, all pad outputs and both side enables read 0.
- R2: On a rising `tck` with `capture_dr` high, the cells load their parallel inputs:
  - an observe-only cell takes its pad input;
  - a pin control cell takes the system output value;
  - an enable cell takes the system enable.
  - Capture wins over shift when both strobes are high.
- R3: On a rising `tck` with `shift_dr` high (and `capture_dr` low), each cell takes the value of its neighbour nearer `tdi`. Position 0 takes `tdi`. When `sel_bypass` is low, `tdo` shows the highest position.
- R4: The chain has `2+4*W` positions, counted from the `tdi` end:
  - 0 is the A-side enable and 1 is the B-side enable.
  - A-side pin i has its observe cell at 2+2i and its control cell at 3+2i.
  - B-side pin i has its observe cell at 2+2W+2i and its control cell at 3+2W+2i.
- R5: Hold latches load the chain values on a falling `tck` while `update_dr` is high. At any other falling edge they keep their value, whatever the chain does.
- R6: With `mode` high, each pad output and each side enable equals its hold latch.
- R7: With `mode` low, each pad output and each side enable equals the system value, whatever the strobes do.
- R8: With `mode` high, a 1 held in an enable cell drives that side's `*_pad_oe` high (outputs on). A 0 held there drives it low.
- R9: With `sel_bypass` high, `tdo` comes from the one-bit bypass stage. That stage loads 0 on `capture_dr` and loads `tdi` on `shift_dr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tdi | input | 1 | Serial data in |
| capture_dr | input | 1 | Parallel load strobe |
| shift_dr | input | 1 | Shift strobe |
| update_dr | input | 1 | Hold-latch load strobe (falling edge) |
| mode | input | 1 | 1: pads from hold latches, 0: pads from system |
| sel_bypass | input | 1 | Route bypass stage to `tdo` |
| a_sys_oe | input | 1 | System enable for A-side outputs |
| b_sys_oe | input | 1 | System enable for B-side outputs |
| a_sys_out | input | W | System values for A-side pads |
| b_sys_out | input | W | System values for B-side pads |
| a_pad_in | input | W | Values read from A-side pads |
| b_pad_in | input | W | Values read from B-side pads |
| a_pad_oe | output | 1 | Enable to A-side pad drivers |
| b_pad_oe | output | 1 | Enable to B-side pad drivers |
| a_pad_out | output | W | Values to A-side pad drivers |
| b_pad_out | output | W | Values to B-side pad drivers |
| tdo | output | 1 | Serial data out |

## Verification
A capture of independent random values on pad inputs, system outputs and enables is followed by a full unload. This proves the position of every cell, since a swapped pair or a wrong cell type gives a wrong bit at a known shift count. Shifting and updating with `mode` low shows that test activity never reaches the pads. Walking enable and data patterns with `mode` high show that the latches, not the chain, drive the pads, and only after an update. A long run of random strobe, mode and bypass mixes is compared every clock against a queue-based model, which exposes ordering, priority and edge errors.

// File: rtl/bsr_pkg.sv
// Package: chain geometry for the transceiver boundary-scan register.
// Positions count from the tdi end. The order is part of the behaviour,
// because the test software addresses cells by their shift count.
package bsr_pkg;

    localparam int SIDE_A = 0;
    localparam int SIDE_B = 1;

    // Total number of cells for W pins per side.
    function automatic int chain_len(input int w);
        return 2 + 4 * w;
    endfunction

    // Position of the enable cell of a side.
    function automatic int oe_pos(input int side);
        return side;
    endfunction

    // Position of the observe-only cell of a pin.
    function automatic int obs_pos(input int side, input int pin, input int w);
        return 2 + side * 2 * w + 2 * pin;
    endfunction

    // Position of the observe-and-control cell of a pin.
    function automatic int ctl_pos(input int side, input int pin, input int w);
        return obs_pos(side, pin, w) + 1;
    endfunction

endpackage

// File: rtl/bsr_obs_cell.sv
// Observe-only cell: one capture/shift flop, no hold latch.
// Assumes the strobes are already decoded and stable around the rising tck.
// Capture has priority over shift.
module bsr_obs_cell (
    input  logic tck,
    input  logic rst_n,
    input  logic capture,
    input  logic shift,
    input  logic par_in,
    input  logic ser_in,
    output logic ser_out
);

    // Capture/shift flop on the rising test clock.
    always_ff @(posedge tck) begin
        if (!rst_n)       ser_out <= 1'b0;
        else if (capture) ser_out <= par_in;
        else if (shift)   ser_out <= ser_in;
    end

endmodule

// File: rtl/bsr_ctl_cell.sv
// Observe-and-control cell: capture/shift flop, hold latch loaded on the
// falling test clock, and an output mux chosen by mode.
// Assumes update is held across the falling edge it is meant for.
module bsr_ctl_cell (
    input  logic tck,
    input  logic rst_n,
    input  logic capture,
    input  logic shift,
    input  logic update,
    input  logic mode,
    input  logic sys_in,
    input  logic ser_in,
    output logic ser_out,
    output logic pin_out
);

    logic hold_q;

    // Capture/shift flop; the parallel input is the system value.
    always_ff @(posedge tck) begin
        if (!rst_n)       ser_out <= 1'b0;
        else if (capture) ser_out <= sys_in;
        else if (shift)   ser_out <= ser_in;
    end

    // Hold latch, loaded on the falling edge so the pins move mid-cycle.
    always_ff @(negedge tck) begin
        if (!rst_n)      hold_q <= 1'b0;
        else if (update) hold_q <= ser_out;
    end

    // Pin source select.
    always_comb begin
        pin_out = mode ? hold_q : sys_in;
    end

endmodule

// File: rtl/bsr_chain.sv
// Boundary-scan data register around a two-sided transceiver.
// Assumes a TAP controller outside supplies decoded capture/shift/update
// strobes, the mode select and the bypass select. Cell order is set by
// bsr_pkg. tdo is taken straight from the last flop (no falling-edge
// retiming), so the controller retimes it if its port needs that.
module bsr_chain #(
    parameter int W = 9
) (
    input  logic         tck,
    input  logic         rst_n,
    input  logic         tdi,
    input  logic         capture_dr,
    input  logic         shift_dr,
    input  logic         update_dr,
    input  logic         mode,
    input  logic         sel_bypass,
    input  logic         a_sys_oe,
    input  logic         b_sys_oe,
    input  logic [W-1:0] a_sys_out,
    input  logic [W-1:0] b_sys_out,
    input  logic [W-1:0] a_pad_in,
    input  logic [W-1:0] b_pad_in,
    output logic         a_pad_oe,
    output logic         b_pad_oe,
    output logic [W-1:0] a_pad_out,
    output logic [W-1:0] b_pad_out,
    output logic         tdo
);

    localparam int L = bsr_pkg::chain_len(W);

    logic [L-1:0]        scan;
    logic [L-1:0]        chain_in;
    logic [1:0]          sys_oe;
    logic [1:0]          pad_oe;
    logic [1:0][W-1:0]   sys_out;
    logic [1:0][W-1:0]   pad_in;
    logic [1:0][W-1:0]   pad_out;
    logic                byp_q;

    // Serial input of each position: its tdi-side neighbour.
    assign chain_in = {scan[L-2:0], tdi};

    // Group the two sides so one generate loop builds both.
    assign sys_oe  = {b_sys_oe, a_sys_oe};
    assign sys_out = {b_sys_out, a_sys_out};
    assign pad_in  = {b_pad_in, a_pad_in};
    assign a_pad_oe  = pad_oe[0];
    assign b_pad_oe  = pad_oe[1];
    assign a_pad_out = pad_out[0];
    assign b_pad_out = pad_out[1];

    for (genvar s = 0; s < 2; s++) begin : g_side
        localparam int PE = bsr_pkg::oe_pos(s);

        bsr_ctl_cell u_oe (
            .tck     (tck),
            .rst_n   (rst_n),
            .capture (capture_dr),
            .shift   (shift_dr),
            .update  (update_dr),
            .mode    (mode),
            .sys_in  (sys_oe[s]),
            .ser_in  (chain_in[PE]),
            .ser_out (scan[PE]),
            .pin_out (pad_oe[s])
        );

        for (genvar i = 0; i < W; i++) begin : g_pin
            localparam int PO = bsr_pkg::obs_pos(s, i, W);
            localparam int PC = bsr_pkg::ctl_pos(s, i, W);

            bsr_obs_cell u_obs (
                .tck     (tck),
                .rst_n   (rst_n),
                .capture (capture_dr),
                .shift   (shift_dr),
                .par_in  (pad_in[s][i]),
                .ser_in  (chain_in[PO]),
                .ser_out (scan[PO])
            );

            bsr_ctl_cell u_ctl (
                .tck     (tck),
                .rst_n   (rst_n),
                .capture (capture_dr),
                .shift   (shift_dr),
                .update  (update_dr),
                .mode    (mode),
                .sys_in  (sys_out[s][i]),
                .ser_in  (chain_in[PC]),
                .ser_out (scan[PC]),
                .pin_out (pad_out[s][i])
            );
        end
    end

    // One-bit bypass stage built as an observe cell on a constant 0.
    bsr_obs_cell u_bypass (
        .tck     (tck),
        .rst_n   (rst_n),
        .capture (capture_dr),
        .shift   (shift_dr),
        .par_in  (1'b0),
        .ser_in  (tdi),
        .ser_out (byp_q)
    );

    // Serial output select.
    always_comb begin
        tdo = sel_bypass ? byp_q : scan[L-1];
    end

endmodule

// File: rtl/bsr_chain_chk.sv
// Checker for bsr_chain, bound to every instance. It observes the ports and
// the internal chain vector, and assumes strobes change away from the edges.
module bsr_chain_chk #(
    parameter int W = 9,
    parameter int L = 2 + 4 * W
) (
    input logic         tck,
    input logic         rst_n,
    input logic         tdi,
    input logic         capture_dr,
    input logic         shift_dr,
    input logic         update_dr,
    input logic         mode,
    input logic         sel_bypass,
    input logic [W-1:0] b_sys_out,
    input logic         a_pad_oe,
    input logic         b_pad_oe,
    input logic [W-1:0] a_pad_out,
    input logic [W-1:0] b_pad_out,
    input logic         tdo,
    input logic [L-1:0] scan
);

    // R1: leaving reset in test mode shows all-zero latches.
    assert_reset_clear_R1: assert property (@(posedge tck) disable iff (!rst_n)
        ($rose(rst_n) && mode) |->
            (!a_pad_oe && !b_pad_oe && a_pad_out == '0 && b_pad_out == '0));

    // R2: after a capture, tdo shows the last B-side system output.
    assert_capture_last_R2: assert property (@(posedge tck) disable iff (!rst_n)
        ($past(capture_dr) && !sel_bypass) |-> (tdo == $past(b_sys_out[W-1])));

    // R3: a shift moves tdi into the first position.
    assert_shift_entry_R3: assert property (@(posedge tck) disable iff (!rst_n)
        ($past(shift_dr) && !$past(capture_dr)) |-> (scan[0] == $past(tdi)));

    // R3: a shift brings the next-to-last position onto tdo.
    assert_shift_out_R3: assert property (@(posedge tck) disable iff (!rst_n)
        ($past(shift_dr) && !$past(capture_dr) && !sel_bypass) |->
            (tdo == $past(scan[L-2])));

    // R5: in test mode without update, the pads do not move.
    assert_hold_stable_R5: assert property (@(posedge tck) disable iff (!rst_n)
        (mode && $past(mode) && !$past(update_dr)) |->
            ($stable(a_pad_out) && $stable(b_pad_out) &&
             $stable(a_pad_oe) && $stable(b_pad_oe)));

    // R9: the bypass stage captures a constant zero.
    assert_bypass_zero_R9: assert property (@(posedge tck) disable iff (!rst_n)
        ($past(capture_dr) && sel_bypass) |-> (tdo == 1'b0));

endmodule

bind bsr_chain bsr_chain_chk #(.W(W), .L(L)) chk_i (
    .tck        (tck),
    .rst_n      (rst_n),
    .tdi        (tdi),
    .capture_dr (capture_dr),
    .shift_dr   (shift_dr),
    .update_dr  (update_dr),
    .mode       (mode),
    .sel_bypass (sel_bypass),
    .b_sys_out  (b_sys_out),
    .a_pad_oe   (a_pad_oe),
    .b_pad_oe   (b_pad_oe),
    .a_pad_out  (a_pad_out),
    .b_pad_out  (b_pad_out),
    .tdo        (tdo),
    .scan       (scan)
);

// File: tb/bsr_chain_tb_top.sv
// Bench for bsr_chain. A queue model mirrors the requirements, updated on
// both clock edges and compared every cycle. Directed checks sit on top.
module bsr_chain_tb_top;

    localparam int W = 9;
    localparam int L = 2 + 4 * W;

    logic tck = 1'b0;
    logic rst_n = 1'b0;
    logic tdi = 1'b0, capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0;
    logic mode = 1'b1, sel_bypass = 1'b0;
    logic a_sys_oe = 1'b0, b_sys_oe = 1'b0;
    logic [W-1:0] a_sys_out = '0, b_sys_out = '0, a_pad_in = '0, b_pad_in = '0;
    logic a_pad_oe, b_pad_oe, tdo;
    logic [W-1:0] a_pad_out, b_pad_out;

    int nchk = 0, nerr = 0;
    bit done = 0, run_cmp = 0;
    bit mq[$];
    bit ml[$];
    bit mb = 0;

    always #5 tck = ~tck;

    bsr_chain #(.W(W)) dut_i (
        .tck(tck), .rst_n(rst_n), .tdi(tdi), .capture_dr(capture_dr),
        .shift_dr(shift_dr), .update_dr(update_dr), .mode(mode),
        .sel_bypass(sel_bypass), .a_sys_oe(a_sys_oe), .b_sys_oe(b_sys_oe),
        .a_sys_out(a_sys_out), .b_sys_out(b_sys_out), .a_pad_in(a_pad_in),
        .b_pad_in(b_pad_in), .a_pad_oe(a_pad_oe), .b_pad_oe(b_pad_oe),
        .a_pad_out(a_pad_out), .b_pad_out(b_pad_out), .tdo(tdo)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Value each position should capture, from the R4 layout.
    function automatic bit pos_val(input int p);
        int q, side, r, pin;
        if (p == 0) return a_sys_oe;
        if (p == 1) return b_sys_oe;
        q = p - 2; side = q / (2 * W); r = q % (2 * W); pin = r / 2;
        if (r % 2 == 1) return side == 0 ? a_sys_out[pin] : b_sys_out[pin];
        return side == 0 ? a_pad_in[pin] : b_pad_in[pin];
    endfunction

    task automatic zero_q(ref bit q[$]);
        q = {};
        for (int k = 0; k < L; k++) q.push_back(1'b0);
    endtask

    // Model: rising edge, then the per-cycle comparison.
    always @(posedge tck) begin
        logic [W-1:0] ea, eb;
        if (!rst_n) begin
            zero_q(mq); mb = 0;
        end else if (capture_dr) begin
            mq = {};
            for (int k = 0; k < L; k++) mq.push_back(pos_val(k));
            mb = 0;
        end else if (shift_dr) begin
            mq.push_front(tdi); void'(mq.pop_back()); mb = tdi;
        end
        #3;
        if (rst_n && run_cmp && !done) begin
            for (int i = 0; i < W; i++) begin
                ea[i] = mode ? ml[3 + 2 * i] : a_sys_out[i];
                eb[i] = mode ? ml[3 + 2 * W + 2 * i] : b_sys_out[i];
            end
            chk(tdo == (sel_bypass ? mb : mq[L-1]), sel_bypass ? "R9 tdo" : "R3 tdo",
                tdo, sel_bypass ? mb : mq[L-1]);
            chk({a_pad_out, b_pad_out} == {ea, eb}, mode ? "R6 pads" : "R7 pads",
                {a_pad_out, b_pad_out}, {ea, eb});
            chk({a_pad_oe, b_pad_oe} == (mode ? {ml[0], ml[1]} : {a_sys_oe, b_sys_oe}),
                "R8 enables", {a_pad_oe, b_pad_oe},
                mode ? {ml[0], ml[1]} : {a_sys_oe, b_sys_oe});
        end
    end

    // Model: falling edge, hold latches.
    always @(negedge tck) begin
        if (!rst_n) zero_q(ml);
        else if (update_dr) ml = mq;
    end

    task automatic tick(input int n = 1);
        for (int k = 0; k < n; k++) begin
            @(negedge tck); #2;
        end
    endtask

    task automatic strobes_off();
        capture_dr = 0; shift_dr = 0; update_dr = 0;
    endtask

    task automatic randomize_sys();
        a_sys_oe = 1'($urandom); b_sys_oe = 1'($urandom);
        a_sys_out = W'($urandom); b_sys_out = W'($urandom);
        a_pad_in = W'($urandom); b_pad_in = W'($urandom);
    endtask

    // Shift in a full chain image (index 0 ends at position 0), then update.
    task automatic load_image(input bit img[L]);
        strobes_off(); shift_dr = 1;
        for (int k = L - 1; k >= 0; k--) begin
            tdi = img[k]; tick();
        end
        strobes_off(); update_dr = 1; tick(); strobes_off();
    endtask

    initial begin
        bit img[L];
        zero_q(mq); zero_q(ml);
        tick(3);
        // R1: reset state seen at the ports in test mode.
        chk(a_pad_out == '0 && b_pad_out == '0, "R1 pads after reset",
            {a_pad_out, b_pad_out}, 0);
        chk(!a_pad_oe && !b_pad_oe && !tdo, "R1 enables and tdo after reset",
            {a_pad_oe, b_pad_oe, tdo}, 0);
        rst_n = 1; run_cmp = 1; tick();

        // R2/R4: capture random values and unload, checking each position.
        mode = 0; randomize_sys(); capture_dr = 1; tick(); strobes_off();
        shift_dr = 1;
        for (int k = 0; k < L; k++) begin
            chk(tdo == pos_val(L - 1 - k), $sformatf("R4 R2 position %0d", L - 1 - k),
                tdo, pos_val(L - 1 - k));
            tdi = 1'($urandom); tick();
        end
        strobes_off();

        // R7: shift and update in system mode leave the pads alone.
        for (int k = 0; k < L; k++) img[k] = 1'b1;
        load_image(img);
        chk(a_pad_out == a_sys_out && b_pad_out == b_sys_out, "R7 pads after update",
            {a_pad_out, b_pad_out}, {a_sys_out, b_sys_out});

        // R6/R8: test mode shows the all-ones image; then enables off.
        mode = 1; tick();
        chk(a_pad_out == '1 && b_pad_out == '1 && a_pad_oe && b_pad_oe,
            "R6 R8 all ones held", {a_pad_oe, b_pad_oe, a_pad_out, b_pad_out}, '1);
        for (int k = 0; k < L; k++) img[k] = (k >= 2) && (k % 3 == 0);
        load_image(img);
        chk(!a_pad_oe && !b_pad_oe, "R8 enables cleared", {a_pad_oe, b_pad_oe}, 0);
        for (int i = 0; i < W; i++)
            chk(a_pad_out[i] == img[3 + 2 * i], $sformatf("R4 A pin %0d", i),
                a_pad_out[i], img[3 + 2 * i]);

        // R5: shifting without update keeps the held values.
        shift_dr = 1; tdi = 1; tick(L); strobes_off();
        chk(!a_pad_oe && !b_pad_oe, "R5 hold without update", {a_pad_oe, b_pad_oe}, 0);
        update_dr = 1; tick(); strobes_off();
        chk(a_pad_oe && b_pad_oe && a_pad_out == '1, "R5 update loads",
            {a_pad_oe, b_pad_oe, a_pad_out}, {2'b11, {W{1'b1}}});

        // R9: bypass captures zero, then passes tdi through one stage.
        sel_bypass = 1; capture_dr = 1; tick(); strobes_off();
        chk(tdo == 1'b0, "R9 bypass capture", tdo, 0);
        shift_dr = 1; tdi = 1; tick(); strobes_off();
        chk(tdo == 1'b1, "R9 bypass shift", tdo, 1);
        sel_bypass = 0;

        // Random mix, compared each cycle by the model.
        for (int n = 0; n < 2000; n++) begin
            int r;
            r = int'($urandom_range(0, 9));
            capture_dr = (r == 0); shift_dr = (r >= 1 && r <= 6) || (r == 9);
            update_dr = (r == 7) || (r == 9);
            tdi = 1'($urandom);
            if ($urandom_range(0, 15) == 0) mode = ~mode;
            if ($urandom_range(0, 15) == 0) sel_bypass = ~sel_bypass;
            if ($urandom_range(0, 3) == 0) randomize_sys();
            tick();
        end
        strobes_off(); tick(2);
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1; nchk++; nerr++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

endmodule